// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2^IDX_W two-bit saturating counters. The table is indexed straight from the program counter and stores no tags. A fetch-side lookup port takes the fetch PC and returns a taken/not-taken guess in the same cycle, with no register on the path. A separate resolution port carries the PC of a branch that has completed, together with its real outcome. The counter that PC selects is moved one step toward that outcome at the next clock edge.

Instructions are word aligned, so the two lowest PC bits are always zero and are skipped. The next IDX_W bits form the table index. Branches whose PCs agree in those bits share one counter. The block gives only a direction. Target computation, recovery after a wrong guess and decode belong to other blocks. Reset is asynchronous and active low. Its release is synchronised internally over two clock edges.

Top module: `bht_predictor`

## Requirements
- R1: While reset is active, and after it, every counter holds 01 (weakly not taken), so every lookup predicts not taken. A single taken update to an entry is then enough to make that entry predict taken.
- R2: The table index is PC[IDX_W+1:2]. PC bits 1:0 have no effect on lookup or update, and PCs that differ by 4 select different entries.
- R3: No tag is kept. Two PCs that differ only above bit IDX_W+1 share one counter, and training through either PC changes the prediction for both.
- R4: The counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. The prediction is the counter MSB. A taken outcome adds one and saturates at 11. A not-taken outcome subtracts one and saturates at 00.
- R5: From a strong state, one opposite outcome leaves the prediction unchanged. A second consecutive opposite outcome flips it.
- R6: The lookup is combinational. If an update hits the looked-up entry in the same cycle, the lookup returns the old counter, and the new value is seen from the next cycle on.
- R7: While up_valid is low, no counter changes, whatever up_pc and up_taken carry.
- R8: For a branch whose outcomes repeat as nine taken followed by one not taken, each loop after warm-up gives exactly one wrong prediction, at the loop exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch (1 = taken) |

## Verification
Every cycle, the assertions check the result of each update. A written counter has moved exactly one step toward the outcome, or has stayed at the rail it was pinned to. A cycle with no update leaves the whole table unchanged, and the prediction output is never unknown. Only the bench scenarios can show the behaviour seen through the ports: index bit selection and aliasing, the read-old order when a lookup and an update meet on one entry, hysteresis across two outcomes, the reset value, and the single exit miss per loop of the nine-taken pattern.

// File: rtl/bht_pkg.sv
`timescale 1ns/1ps
package bht_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;
endpackage

// File: rtl/bht_rst_sync.sv
`timescale 1ns/1ps
module bht_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/bht_index.sv
`timescale 1ns/1ps
module bht_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 12
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  localparam int LSB = 2;
  localparam int MSB = IDX_W + LSB - 1;

  assign idx = pc[MSB:LSB];

  initial begin
    a_r2_pc_wide: assert (PC_W > MSB);
  end
endmodule

// File: rtl/bht_ctr_next.sv
`timescale 1ns/1ps
module bht_ctr_next
  import bht_pkg::*;
(
  input  ctr_e cur,
  input  logic taken,
  output ctr_e nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
      default: nxt = CTR_WNT;
    endcase
  end
endmodule

// File: rtl/bht_table.sv
`timescale 1ns/1ps
module bht_table
  import bht_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][1:0] mem_q;
  ctr_e                  wr_cur;
  ctr_e                  wr_nxt;

  // next-state: counter step for the entry under update
  always_comb begin
    wr_cur = ctr_e'(mem_q[wr_idx]);
  end

  bht_ctr_next u_step (
    .cur   (wr_cur),
    .taken (wr_taken),
    .nxt   (wr_nxt)
  );

  // register: enabled write of one entry
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= {DEPTH{2'b01}};
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_nxt;
    end
  end

  always_comb begin
    rd_ctr = ctr_e'(mem_q[rd_idx]);
  end

  // assertion support: remember what the last update saw
  logic             chk_en_q;
  logic             chk_tk_q;
  logic [IDX_W-1:0] chk_idx_q;
  logic [1:0]       chk_old_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_en_q  <= 1'b0;
      chk_tk_q  <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= 2'b01;
    end else begin
      chk_en_q  <= wr_en;
      chk_tk_q  <= wr_taken;
      chk_idx_q <= wr_idx;
      chk_old_q <= mem_q[wr_idx];
    end
  end

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_ni)
    (chk_en_q && chk_tk_q && chk_old_q != 2'b11) |-> (mem_q[chk_idx_q] == chk_old_q + 2'b01));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_ni)
    (chk_en_q && !chk_tk_q && chk_old_q != 2'b00) |-> (mem_q[chk_idx_q] == chk_old_q - 2'b01));

  a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_ni)
    (chk_en_q && chk_tk_q && chk_old_q == 2'b11) |-> (mem_q[chk_idx_q] == 2'b11));

  a_r4_sat_low: assert property (@(posedge clk) disable iff (!rst_ni)
    (chk_en_q && !chk_tk_q && chk_old_q == 2'b00) |-> (mem_q[chk_idx_q] == 2'b00));

  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_ni)
    !chk_en_q |-> $stable(mem_q));
endmodule

// File: rtl/bht_predictor.sv
`timescale 1ns/1ps
module bht_predictor
  import bht_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  logic             rst_int_n;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  ctr_e             lk_ctr;

  bht_rst_sync u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_int_n)
  );

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (
    .pc  (lk_pc),
    .idx (lk_idx)
  );

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_idx (
    .pc  (up_pc),
    .idx (up_idx)
  );

  bht_table #(.IDX_W(IDX_W)) u_tab (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_taken (up_taken)
  );

  assign lk_taken = lk_ctr[1];

  a_r6_pred_known: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$isunknown(lk_taken));
endmodule

// File: tb/sim_bht_predictor.sv
`timescale 1ns/1ps
module sim_bht_predictor;
  localparam int PC_W  = 32;
  localparam int IDX_W = 12;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic [PC_W-1:0] up_pc;
  logic            up_valid;
  logic            up_taken;
  logic            lk_taken;

  always #10 clk = ~clk;

  bht_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .up_valid (up_valid),
    .up_pc    (up_pc),
    .up_taken (up_taken)
  );

  typedef struct {
    logic  exp;
    logic  outc;
    bit    cnt;
    string tag;
  } item_t;

  item_t sbq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    loop_miss = 0;
  int    mdl [DEPTH];
  bit    done = 1'b0;

  function automatic int ix(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) mdl[i] = 1;
  endtask

  // driver: drive one cycle, push the expected prediction
  task automatic step(input logic [PC_W-1:0] lpc, input bit chk, input string tag,
                      input bit uv, input logic [PC_W-1:0] upc, input bit ut,
                      input bit cnt, input bit outc);
    item_t it;
    @(posedge clk); #2;
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    if (chk) begin
      it.exp = (mdl[ix(lpc)] >= 2);
      it.outc = outc; it.cnt = cnt; it.tag = tag;
      sbq.push_back(it);
    end
    if (uv) begin
      if (ut && mdl[ix(upc)] < 3) mdl[ix(upc)] = mdl[ix(upc)] + 1;
      else if (!ut && mdl[ix(upc)] > 0) mdl[ix(upc)] = mdl[ix(upc)] - 1;
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string tag);
    step(pc, 1'b1, tag, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input bit t);
    step('0, 1'b0, "", 1'b1, pc, t, 1'b0, 1'b0);
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare mid-cycle, away from the clock edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #12;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        n_chk++;
        if (lk_taken !== it.exp) begin
          n_fail++;
          $display("FAIL %s: lk_taken=%0b expected %0b", it.tag, lk_taken, it.exp);
        end
        if (it.cnt && lk_taken !== it.outc) loop_miss++;
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_pc = '0; up_pc = '0; up_valid = 1'b0; up_taken = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset value predicts not taken, one taken flips it
    look(32'h0000_0000, "R1 reset");
    look(32'h0000_3FFC, "R1 reset");
    train(32'h0000_0040, 1'b1);
    look(32'h0000_0040, "R1 one step from 01");

    // R2: low two bits ignored, +4 is another entry
    look(32'h0000_0043, "R2 low bits ignored");
    look(32'h0000_0044, "R2 neighbour entry");
    train(32'h0000_0087, 1'b1);
    look(32'h0000_0084, "R2 update low bits ignored");

    // R3: aliasing above the index
    look(32'h0000_4040, "R3 alias read");
    train(32'h0001_0100, 1'b1);
    look(32'h0000_0100, "R3 alias trained");

    // R4 / R5: saturation and hysteresis on 0x80
    train(32'h0000_0080, 1'b1);
    train(32'h0000_0080, 1'b1);
    train(32'h0000_0080, 1'b1);
    train(32'h0000_0080, 1'b0);
    look(32'h0000_0080, "R5 one miss keeps taken");
    train(32'h0000_0080, 1'b0);
    look(32'h0000_0080, "R5 second miss flips");
    train(32'h0000_0080, 1'b0);
    train(32'h0000_0080, 1'b0);
    train(32'h0000_0080, 1'b1);
    look(32'h0000_0080, "R4 low saturation");
    train(32'h0000_0080, 1'b1);
    look(32'h0000_0080, "R4 count up");

    // R6: same-cycle lookup and update read the old value
    step(32'h0000_00C0, 1'b1, "R6 read old", 1'b1, 32'h0000_00C0, 1'b1, 1'b0, 1'b0);
    look(32'h0000_00C0, "R6 new value next cycle");

    // R7: updates with up_valid low are ignored
    step(32'h0000_0200, 1'b1, "R7 ignored taken", 1'b0, 32'h0000_0200, 1'b1, 1'b0, 1'b0);
    step(32'h0000_0200, 1'b1, "R7 ignored taken", 1'b0, 32'h0000_0200, 1'b1, 1'b0, 1'b0);
    step(32'h0000_0040, 1'b1, "R7 ignored not taken", 1'b0, 32'h0000_0040, 1'b0, 1'b0, 1'b0);
    look(32'h0000_0040, "R7 entry unchanged");

    // R8: loop of nine taken and one not taken on 0x300
    for (int lp = 0; lp < 6; lp++) begin
      for (int it = 0; it < 10; it++) begin
        step(32'h0000_0300, 1'b1, "R8 loop", 1'b1, 32'h0000_0300, (it != 9),
             (lp > 0), (it != 9));
      end
    end
    repeat (2) @(posedge clk);
    check_int("R8 misses after warm-up", loop_miss, 5);

    // R1: reset mid-run returns trained entries to 01
    @(posedge clk); #2;
    up_valid = 1'b0;
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    look(32'h0000_0040, "R1 reset after training");
    look(32'h0000_0300, "R1 reset after training");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule